// File: doc/BRIEF.md
# Dual-Dataflow Convolution Mesh

This block is an N×N mesh of multiply-accumulate cells that runs one convolution tile at a time in one of two dataflows, picked per tile by a configuration bit sampled at `start`. In output-block mode every cell owns one pixel of an N×N output block. The input block is loaded first, one row per cycle from the top edge. Filter weights then arrive one per beat on the broadcast stream, and activations move between neighbouring cells, so no cell reloads them. After the last input channel the accumulated block leaves through the bottom edge, one row per cycle.

In matrix-vector mode the load path fills the cells with an N×N weight matrix: cell row r serves input channel r and cell column c serves output channel c. Each broadcast beat then carries N activations, one per input channel. Every column sums its products in a pipelined chain from top to bottom, and the bottom row emits one sum per output channel for every beat.

A surrounding sequencer supplies the load rows, the edge (halo) data and the stream beats in the order the requirements fix. The block reports the end of a tile with a one-cycle `done` pulse.

Top module: `sa_wsos_array`

## Requirements
- R1: After reset, `res_valid`, `done`, `pre_ready` and `bc_ready` are all low, and stay low until a `start` is accepted.
- R2: After `start`, the mesh takes exactly N load rows, one on each cycle with `pre_valid` and `pre_ready` both high. Lane k of a row is `pre_data[k*DW +: DW]` and feeds column k. Rows enter at the top and shift down, so the first row accepted ends in the bottom cell row. After the N-th row, `pre_ready` goes low.
- R3: In output-block mode (`cfg_ws`=0), filter taps run in row-major order, one per broadcast beat, with the weight in lane 0 of `bc_data`. The first tap of a channel needs only the beat. A later tap in the same filter row joins the beat with one load-path word, whose lane r enters the right-edge cell of row r while all activations move one column left. The first tap of a new filter row also joins a load-path word, whose lane c enters the bottom cell of column c while the row-start activations move one row up.
- R4: In output-block mode, the load-and-tap sequence repeats for `cfg_chan` input channels. Each cell's products add into its own sum across all channels, and the sums start from zero at `start`.
- R5: After the last tap, the block emits N result rows on N consecutive cycles with `res_valid` high, bottom cell row first. Lane c of `res_data` (`[c*ACCW +: ACCW]`, signed) is the sum of the cell in column c.
- R6: In matrix-vector mode (`cfg_ws`=1), the N load rows fill the weights, with the first row accepted landing in cell row N-1 (input channel N-1).
- R7: In matrix-vector mode, for each beat with activations x (lane r = input channel r), result lane c equals the sum over r of weight[r][c]·x[r].
- R8: In matrix-vector mode, the block accepts exactly `cfg_beats` beats, then holds `bc_ready` low. Each beat's result appears with `res_valid` exactly N cycles after the cycle in which the beat was accepted, and results keep beat order.
- R9: `done` is high for exactly one cycle, in the cycle that carries the tile's last result, and never without `res_valid`. The block is idle in the next cycle.
- R10: A `start` raised while a tile is in progress has no effect on that tile's results.
- R11: The mode and the shape fields are sampled only in the cycle a `start` is accepted, so they may change during a tile. Tiles of either mode may follow each other with no idle cycle between `done` and the next `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a tile (accepted only when idle) |
| cfg_ws | input | 1 | 1 = matrix-vector mode, 0 = output-block mode |
| cfg_filt | input | FW | Filter side F, 1..FMAX (output-block mode) |
| cfg_chan | input | CW | Input channel count, at least 1 (output-block mode) |
| cfg_beats | input | BW | Number of stream beats, at least 1 (matrix-vector mode) |
| pre_valid | input | 1 | Load-path word valid |
| pre_ready | output | 1 | Load path accepts a word |
| pre_data | input | N*DW | Load-path word, N signed lanes |
| bc_valid | input | 1 | Broadcast beat valid |
| bc_ready | output | 1 | Broadcast beat accepted |
| bc_data | input | N*DW | Broadcast beat, N signed lanes |
| res_valid | output | 1 | Result row valid |
| res_data | output | N*ACCW | Result row, N signed lanes |
| done | output | 1 | One-cycle end-of-tile pulse |

## Verification
In output-block mode the N result rows are due on N back-to-back cycles once the last tap is taken. The bench records the cycle counter at every result and checks that each row is one cycle after the row before it, with `done` on the N-th. In matrix-vector mode every sum is due exactly N cycles after the cycle its beat was accepted. The bench stores the counter value at each acceptance and compares it with the counter value seen at the matching result. All samples are taken at the falling clock edge, and inputs change only after a rising edge has been passed.

// File: rtl/sa_pkg.sv
package sa_pkg;

    typedef enum logic [3:0] {
        PE_HOLD,
        PE_CLR,
        PE_LOAD_ACT,
        PE_LOAD_WGT,
        PE_TAP0,
        PE_TAP_LEFT,
        PE_TAP_UP,
        PE_DRAIN,
        PE_WS
    } pe_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_TAPS,
        ST_DRAIN,
        ST_STREAM
    } ctl_state_e;

endpackage

// File: rtl/sa_pe.sv
module sa_pe
    import sa_pkg::*;
#(
    parameter int DW   = 8,
    parameter int ACCW = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  pe_op_e                 op,
    input  logic signed [DW-1:0]   bcast,
    input  logic signed [DW-1:0]   x_in,
    input  logic signed [DW-1:0]   n_act,
    input  logic signed [DW-1:0]   n_wgt,
    input  logic signed [DW-1:0]   e_act,
    input  logic signed [DW-1:0]   s_base,
    input  logic signed [ACCW-1:0] n_acc,
    output logic signed [DW-1:0]   act_o,
    output logic signed [DW-1:0]   base_o,
    output logic signed [DW-1:0]   wgt_o,
    output logic signed [ACCW-1:0] acc_o
);
    localparam int PW = 2 * DW;

    typedef struct packed {
        logic signed [DW-1:0]   act;
        logic signed [DW-1:0]   base;
        logic signed [DW-1:0]   wgt;
        logic signed [ACCW-1:0] acc;
    } pe_t;

    pe_t cur_q, nxt_d;
    logic signed [DW-1:0]   mul_a_d, mul_b_d;
    logic signed [PW-1:0]   prod_d;
    logic signed [ACCW-1:0] prod_ext_d;

    // one multiplier, operands steered by the operation
    always_comb begin
        nxt_d   = cur_q;
        mul_a_d = bcast;
        mul_b_d = cur_q.act;
        case (op)
            PE_TAP_LEFT: mul_b_d = e_act;
            PE_TAP_UP:   mul_b_d = s_base;
            PE_WS: begin
                mul_a_d = cur_q.wgt;
                mul_b_d = x_in;
            end
            default: ;
        endcase
        prod_d     = mul_a_d * mul_b_d;
        prod_ext_d = {{(ACCW-PW){prod_d[PW-1]}}, prod_d};
        case (op)
            PE_CLR:      nxt_d.acc = '0;
            PE_LOAD_ACT: begin
                nxt_d.act  = n_act;
                nxt_d.base = n_act;
            end
            PE_LOAD_WGT: nxt_d.wgt = n_wgt;
            PE_TAP0:     nxt_d.acc = cur_q.acc + prod_ext_d;
            PE_TAP_LEFT: begin
                nxt_d.act = e_act;
                nxt_d.acc = cur_q.acc + prod_ext_d;
            end
            PE_TAP_UP: begin
                nxt_d.act  = s_base;
                nxt_d.base = s_base;
                nxt_d.acc  = cur_q.acc + prod_ext_d;
            end
            PE_DRAIN:    nxt_d.acc = n_acc;
            PE_WS:       nxt_d.acc = n_acc + prod_ext_d;
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign act_o  = cur_q.act;
    assign base_o = cur_q.base;
    assign wgt_o  = cur_q.wgt;
    assign acc_o  = cur_q.acc;

endmodule

// File: rtl/sa_mesh.sv
module sa_mesh
    import sa_pkg::*;
#(
    parameter int N    = 4,
    parameter int DW   = 8,
    parameter int ACCW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  pe_op_e            op,
    input  logic [N*DW-1:0]   edge_in,
    input  logic [N*DW-1:0]   lanes,
    output logic [N*ACCW-1:0] bot_acc
);
    logic signed [DW-1:0]   act_w  [N][N];
    logic signed [DW-1:0]   base_w [N][N];
    logic signed [DW-1:0]   wgt_w  [N][N];
    logic signed [ACCW-1:0] acc_w  [N][N];
    logic signed [DW-1:0]   xin_w  [N];
    logic signed [DW-1:0]   bcast_w;

    assign bcast_w = lanes[DW-1:0];

    // input skew: row r sees its lane r cycles late, matching the column chain
    for (genvar r = 0; r < N; r++) begin : g_skew
        if (r == 0) begin : g_direct
            assign xin_w[0] = lanes[DW-1:0];
        end else begin : g_delay
            logic signed [DW-1:0] sk_q [r];
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    for (int k = 0; k < r; k++) sk_q[k] <= '0;
                end else begin
                    sk_q[0] <= lanes[r*DW +: DW];
                    for (int k = 1; k < r; k++) sk_q[k] <= sk_q[k-1];
                end
            end
            assign xin_w[r] = sk_q[r-1];
        end
    end

    for (genvar r = 0; r < N; r++) begin : g_row
        for (genvar c = 0; c < N; c++) begin : g_col
            logic signed [DW-1:0]   n_act, n_wgt, e_act, s_base;
            logic signed [ACCW-1:0] n_acc;

            if (r == 0) begin : g_top
                assign n_act = edge_in[c*DW +: DW];
                assign n_wgt = edge_in[c*DW +: DW];
                assign n_acc = '0;
            end else begin : g_inner_n
                assign n_act = act_w[r-1][c];
                assign n_wgt = wgt_w[r-1][c];
                assign n_acc = acc_w[r-1][c];
            end

            if (c == N-1) begin : g_right
                assign e_act = edge_in[r*DW +: DW];
            end else begin : g_inner_e
                assign e_act = act_w[r][c+1];
            end

            if (r == N-1) begin : g_bottom
                assign s_base = edge_in[c*DW +: DW];
            end else begin : g_inner_s
                assign s_base = base_w[r+1][c];
            end

            sa_pe #(.DW(DW), .ACCW(ACCW)) u_pe (
                .clk    (clk),
                .rst_n  (rst_n),
                .op     (op),
                .bcast  (bcast_w),
                .x_in   (xin_w[r]),
                .n_act  (n_act),
                .n_wgt  (n_wgt),
                .e_act  (e_act),
                .s_base (s_base),
                .n_acc  (n_acc),
                .act_o  (act_w[r][c]),
                .base_o (base_w[r][c]),
                .wgt_o  (wgt_w[r][c]),
                .acc_o  (acc_w[r][c])
            );
        end
    end

    for (genvar c = 0; c < N; c++) begin : g_out
        assign bot_acc[c*ACCW +: ACCW] = acc_w[N-1][c];
    end

endmodule

// File: rtl/sa_ctrl.sv
module sa_ctrl
    import sa_pkg::*;
#(
    parameter int N  = 4,
    parameter int FW = 3,
    parameter int CW = 8,
    parameter int BW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          cfg_ws,
    input  logic [FW-1:0] cfg_filt,
    input  logic [CW-1:0] cfg_chan,
    input  logic [BW-1:0] cfg_beats,
    input  logic          pre_valid,
    output logic          pre_ready,
    input  logic          bc_valid,
    output logic          bc_ready,
    output pe_op_e        pe_op,
    output logic          res_valid,
    output logic          done,
    output logic          run_ws
);
    localparam int NW = (N > 1) ? $clog2(N) : 1;

    typedef struct packed {
        ctl_state_e    st;
        logic          ws;
        logic [FW-1:0] filt;
        logic [FW-1:0] ti;
        logic [FW-1:0] tj;
        logic [CW-1:0] chan;
        logic [CW-1:0] ch;
        logic [BW-1:0] beats;
        logic [BW-1:0] sent;
        logic [BW-1:0] got;
        logic [NW-1:0] cnt;
        logic [N-1:0]  vpipe;
    } ctl_t;

    ctl_t cur_q, nxt_d;
    logic first_d, fire_d;

    always_comb begin
        nxt_d     = cur_q;
        nxt_d.vpipe = {cur_q.vpipe[N-2:0], 1'b0};
        pe_op     = PE_HOLD;
        pre_ready = 1'b0;
        bc_ready  = 1'b0;
        res_valid = 1'b0;
        done      = 1'b0;
        first_d   = (cur_q.ti == '0) && (cur_q.tj == '0);
        fire_d    = 1'b0;

        case (cur_q.st)
            ST_IDLE: begin
                if (start) begin
                    nxt_d.ws    = cfg_ws;
                    nxt_d.filt  = cfg_filt;
                    nxt_d.chan  = cfg_chan;
                    nxt_d.beats = cfg_beats;
                    nxt_d.ti    = '0;
                    nxt_d.tj    = '0;
                    nxt_d.ch    = '0;
                    nxt_d.sent  = '0;
                    nxt_d.got   = '0;
                    nxt_d.cnt   = '0;
                    nxt_d.st    = ST_LOAD;
                    pe_op       = PE_CLR;
                end
            end

            ST_LOAD: begin
                pre_ready = 1'b1;
                if (pre_valid) begin
                    pe_op = cur_q.ws ? PE_LOAD_WGT : PE_LOAD_ACT;
                    if (cur_q.cnt == NW'(N-1)) begin
                        nxt_d.cnt = '0;
                        nxt_d.ti  = '0;
                        nxt_d.tj  = '0;
                        nxt_d.st  = cur_q.ws ? ST_STREAM : ST_TAPS;
                    end else begin
                        nxt_d.cnt = cur_q.cnt + NW'(1);
                    end
                end
            end

            ST_TAPS: begin
                // later taps join a weight beat with a halo word
                bc_ready  = first_d | pre_valid;
                pre_ready = ~first_d & bc_valid;
                fire_d    = bc_valid & (first_d | pre_valid);
                if (fire_d) begin
                    if (first_d)              pe_op = PE_TAP0;
                    else if (cur_q.tj != '0)  pe_op = PE_TAP_LEFT;
                    else                      pe_op = PE_TAP_UP;
                    if (cur_q.tj == cur_q.filt - FW'(1)) begin
                        nxt_d.tj = '0;
                        if (cur_q.ti == cur_q.filt - FW'(1)) begin
                            nxt_d.ti  = '0;
                            nxt_d.cnt = '0;
                            if (cur_q.ch == cur_q.chan - CW'(1)) begin
                                nxt_d.st = ST_DRAIN;
                            end else begin
                                nxt_d.ch = cur_q.ch + CW'(1);
                                nxt_d.st = ST_LOAD;
                            end
                        end else begin
                            nxt_d.ti = cur_q.ti + FW'(1);
                        end
                    end else begin
                        nxt_d.tj = cur_q.tj + FW'(1);
                    end
                end
            end

            ST_DRAIN: begin
                res_valid = 1'b1;
                pe_op     = PE_DRAIN;
                if (cur_q.cnt == NW'(N-1)) begin
                    done      = 1'b1;
                    nxt_d.cnt = '0;
                    nxt_d.st  = ST_IDLE;
                end else begin
                    nxt_d.cnt = cur_q.cnt + NW'(1);
                end
            end

            ST_STREAM: begin
                pe_op    = PE_WS;
                bc_ready = (cur_q.sent != cur_q.beats);
                fire_d   = bc_valid & bc_ready;
                if (fire_d) begin
                    nxt_d.sent     = cur_q.sent + BW'(1);
                    nxt_d.vpipe[0] = 1'b1;
                end
                res_valid = cur_q.vpipe[N-1];
                if (cur_q.vpipe[N-1]) begin
                    nxt_d.got = cur_q.got + BW'(1);
                    if (cur_q.got == cur_q.beats - BW'(1)) begin
                        done     = 1'b1;
                        nxt_d.st = ST_IDLE;
                    end
                end
            end

            default: nxt_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign run_ws = cur_q.ws;

endmodule

// File: rtl/sa_wsos_array.sv
module sa_wsos_array
    import sa_pkg::*;
#(
    parameter int N    = 4,
    parameter int DW   = 8,
    parameter int ACCW = 32,
    parameter int FMAX = 7,
    parameter int CW   = 8,
    parameter int BW   = 12,
    localparam int FW  = $clog2(FMAX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              cfg_ws,
    input  logic [FW-1:0]     cfg_filt,
    input  logic [CW-1:0]     cfg_chan,
    input  logic [BW-1:0]     cfg_beats,
    input  logic              pre_valid,
    output logic              pre_ready,
    input  logic [N*DW-1:0]   pre_data,
    input  logic              bc_valid,
    output logic              bc_ready,
    input  logic [N*DW-1:0]   bc_data,
    output logic              res_valid,
    output logic [N*ACCW-1:0] res_data,
    output logic              done
);
    pe_op_e op_w;
    logic   ws_mode;

    sa_ctrl #(.N(N), .FW(FW), .CW(CW), .BW(BW)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .cfg_ws    (cfg_ws),
        .cfg_filt  (cfg_filt),
        .cfg_chan  (cfg_chan),
        .cfg_beats (cfg_beats),
        .pre_valid (pre_valid),
        .pre_ready (pre_ready),
        .bc_valid  (bc_valid),
        .bc_ready  (bc_ready),
        .pe_op     (op_w),
        .res_valid (res_valid),
        .done      (done),
        .run_ws    (ws_mode)
    );

    sa_mesh #(.N(N), .DW(DW), .ACCW(ACCW)) u_mesh (
        .clk     (clk),
        .rst_n   (rst_n),
        .op      (op_w),
        .edge_in (pre_data),
        .lanes   (bc_data),
        .bot_acc (res_data)
    );

endmodule

// File: rtl/sa_wsos_array_chk.sv
module sa_wsos_array_chk #(
    parameter int N = 4
) (
    input logic clk,
    input logic rst_n,
    input logic done,
    input logic res_valid,
    input logic pre_ready,
    input logic bc_ready,
    input logic bc_valid,
    input logic run_ws
);
    p_done_has_result_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> res_valid);

    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_idle_after_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!pre_ready && !bc_ready));

    p_drain_consecutive_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !done && !run_ws) |=> res_valid);

    p_ws_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bc_valid && bc_ready && run_ws) |-> ##N res_valid);

endmodule

bind sa_wsos_array sa_wsos_array_chk #(.N(N)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .done      (done),
    .res_valid (res_valid),
    .pre_ready (pre_ready),
    .bc_ready  (bc_ready),
    .bc_valid  (bc_valid),
    .run_ws    (ws_mode)
);

// File: tb/tb_sa_wsos_array.sv
module tb_sa_wsos_array;
    localparam int N    = 4;
    localparam int DW   = 8;
    localparam int ACCW = 32;
    localparam int FMAX = 7;
    localparam int CW   = 8;
    localparam int BW   = 12;
    localparam int FW   = $clog2(FMAX + 1);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic              cfg_ws = 1'b0;
    logic [FW-1:0]     cfg_filt = '0;
    logic [CW-1:0]     cfg_chan = '0;
    logic [BW-1:0]     cfg_beats = '0;
    logic              pre_valid = 1'b0;
    logic              pre_ready;
    logic [N*DW-1:0]   pre_data = '0;
    logic              bc_valid = 1'b0;
    logic              bc_ready;
    logic [N*DW-1:0]   bc_data = '0;
    logic              res_valid;
    logic [N*ACCW-1:0] res_data;
    logic              done;

    sa_wsos_array #(.N(N), .DW(DW), .ACCW(ACCW), .FMAX(FMAX), .CW(CW), .BW(BW)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_ws(cfg_ws), .cfg_filt(cfg_filt),
        .cfg_chan(cfg_chan), .cfg_beats(cfg_beats), .pre_valid(pre_valid),
        .pre_ready(pre_ready), .pre_data(pre_data), .bc_valid(bc_valid),
        .bc_ready(bc_ready), .bc_data(bc_data), .res_valid(res_valid),
        .res_data(res_data), .done(done)
    );

    always #5 clk = ~clk;

    int ntests = 0;
    int nfail  = 0;
    int cyc    = 0;
    int nres   = 0;
    int ndone  = 0;
    int done_at = 0;
    logic [N*ACCW-1:0] rows [256];
    int rcyc [256];

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (rst_n) begin
            if (res_valid) begin
                rows[nres % 256] = res_data;
                rcyc[nres % 256] = cyc;
                nres = nres + 1;
            end
            if (done) begin
                ndone   = ndone + 1;
                done_at = nres;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        ntests++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int rnd8();
        return int'($urandom_range(255)) - 128;
    endfunction

    task automatic gap();
        repeat ($urandom_range(1)) @(negedge clk);
    endtask

    task automatic go(input bit ws, input int f, input int ch, input int nb);
        @(negedge clk);
        start = 1'b1; cfg_ws = ws;
        cfg_filt = FW'(f); cfg_chan = CW'(ch); cfg_beats = BW'(nb);
        @(posedge clk); #1;
        start = 1'b0;
        // R11: scramble the shape fields once the tile has begun
        cfg_ws = ~ws; cfg_filt = FW'(1); cfg_chan = CW'(1); cfg_beats = BW'(1);
    endtask

    task automatic pre_beat(input logic [N*DW-1:0] d);
        @(negedge clk);
        pre_valid = 1'b1; pre_data = d;
        #1;
        while (!pre_ready) begin @(negedge clk); #1; end
        @(posedge clk); #1;
        pre_valid = 1'b0;
    endtask

    task automatic tap(input bit first, input int w, input logic [N*DW-1:0] halo);
        @(negedge clk);
        bc_valid = 1'b1; bc_data = '0; bc_data[DW-1:0] = w[DW-1:0];
        if (!first) begin pre_valid = 1'b1; pre_data = halo; end
        #1;
        while (!(bc_ready && (first || pre_ready))) begin @(negedge clk); #1; end
        @(posedge clk); #1;
        bc_valid = 1'b0; pre_valid = 1'b0;
    endtask

    task automatic ws_beat(input logic [N*DW-1:0] x, output int acc_cyc);
        @(negedge clk);
        bc_valid = 1'b1; bc_data = x;
        #1;
        while (!bc_ready) begin @(negedge clk); #1; end
        acc_cyc = cyc;
        @(posedge clk); #1;
        bc_valid = 1'b0;
    endtask

    task automatic wait_done(input int d0);
        while (ndone == d0) @(negedge clk);
        @(negedge clk);
    endtask

    // output-block tile: F x F filter over C channels
    task automatic run_os(input int F, input int C, input bit extreme, input bit poke);
        int A [3][8][8];
        int W [3][5][5];
        longint E [N][N];
        int base, d0;
        logic [N*DW-1:0] v;
        for (int ch = 0; ch < C; ch++) begin
            for (int y = 0; y < 8; y++)
                for (int x = 0; x < 8; x++) A[ch][y][x] = extreme ? -128 : rnd8();
            for (int i = 0; i < 5; i++)
                for (int j = 0; j < 5; j++) W[ch][i][j] = extreme ? -128 : rnd8();
        end
        for (int r = 0; r < N; r++)
            for (int c = 0; c < N; c++) begin
                E[r][c] = 0;
                for (int ch = 0; ch < C; ch++)
                    for (int i = 0; i < F; i++)
                        for (int j = 0; j < F; j++)
                            E[r][c] += longint'(W[ch][i][j]) * longint'(A[ch][r+i][c+j]);
            end
        base = nres; d0 = ndone;
        go(1'b0, F, C, 1);
        for (int ch = 0; ch < C; ch++) begin
            for (int rr = N-1; rr >= 0; rr--) begin
                for (int c = 0; c < N; c++) v[c*DW +: DW] = A[ch][rr][c][DW-1:0];
                pre_beat(v);
                if (poke && ch == 0 && rr == N-1) begin
                    start = 1'b1; cfg_ws = 1'b1; cfg_beats = BW'(3);
                    @(posedge clk); #1;
                    start = 1'b0;
                end
            end
            chk(pre_ready == 1'b0, "R2", "pre_ready after N rows", pre_ready, 0);
            chk(bc_ready == 1'b1, "R3", "first tap ready", bc_ready, 1);
            for (int i = 0; i < F; i++)
                for (int j = 0; j < F; j++) begin
                    v = '0;
                    if (j > 0) begin
                        for (int r = 0; r < N; r++) v[r*DW +: DW] = A[ch][r+i][N-1+j][DW-1:0];
                    end else begin
                        for (int c = 0; c < N; c++) v[c*DW +: DW] = A[ch][N-1+i][c][DW-1:0];
                    end
                    gap();
                    tap(i == 0 && j == 0, W[ch][i][j], v);
                end
        end
        wait_done(d0);
        chk(nres - base == N, "R5", "row count", nres - base, N);
        chk(ndone - d0 == 1, "R9", "done pulses", ndone - d0, 1);
        chk(done_at == base + N, "R9", "done on last row", done_at, base + N);
        for (int k = 0; k < N; k++) begin
            if (k > 0)
                chk(rcyc[(base+k)%256] == rcyc[(base+k-1)%256] + 1, "R5", "row spacing",
                    rcyc[(base+k)%256] - rcyc[(base+k-1)%256], 1);
            for (int c = 0; c < N; c++) begin
                longint got;
                got = longint'($signed(rows[(base+k)%256][c*ACCW +: ACCW]));
                chk(got == E[N-1-k][c], (C > 1) ? "R4" : (poke ? "R10" : "R3"),
                    "output-block sum", got, E[N-1-k][c]);
            end
        end
    endtask

    // matrix-vector tile with nb beats
    task automatic run_ws(input int nb, input bit gaps);
        int Wm [N][N];
        int X [16][N];
        int ac [16];
        int base, d0;
        logic [N*DW-1:0] v;
        for (int r = 0; r < N; r++)
            for (int c = 0; c < N; c++) Wm[r][c] = rnd8();
        for (int b = 0; b < nb; b++)
            for (int r = 0; r < N; r++) X[b][r] = rnd8();
        base = nres; d0 = ndone;
        go(1'b1, 3, 2, nb);
        for (int rr = N-1; rr >= 0; rr--) begin
            for (int c = 0; c < N; c++) v[c*DW +: DW] = Wm[rr][c][DW-1:0];
            pre_beat(v);
        end
        chk(pre_ready == 1'b0, "R2", "pre_ready after N weight rows", pre_ready, 0);
        for (int b = 0; b < nb; b++) begin
            for (int r = 0; r < N; r++) v[r*DW +: DW] = X[b][r][DW-1:0];
            if (gaps) gap();
            ws_beat(v, ac[b]);
        end
        chk(bc_ready == 1'b0, "R8", "bc_ready after last beat", bc_ready, 0);
        wait_done(d0);
        chk(nres - base == nb, "R8", "result count", nres - base, nb);
        chk(ndone - d0 == 1, "R9", "done pulses", ndone - d0, 1);
        chk(done_at == base + nb, "R9", "done on last result", done_at, base + nb);
        for (int b = 0; b < nb; b++) begin
            chk(rcyc[(base+b)%256] == ac[b] + N, "R8", "beat latency",
                rcyc[(base+b)%256] - ac[b], N);
            for (int c = 0; c < N; c++) begin
                longint exp, got;
                exp = 0;
                for (int r = 0; r < N; r++) exp += longint'(Wm[r][c]) * longint'(X[b][r]);
                got = longint'($signed(rows[(base+b)%256][c*ACCW +: ACCW]));
                chk(got == exp, "R7 (weights per R6)", "column sum", got, exp);
            end
        end
    endtask

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        #1;
        chk(res_valid == 1'b0, "R1", "res_valid in reset", res_valid, 0);
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk(res_valid == 1'b0 && done == 1'b0, "R1", "outputs after reset",
            {res_valid, done}, 0);
        chk(pre_ready == 1'b0 && bc_ready == 1'b0, "R1", "readies after reset",
            {pre_ready, bc_ready}, 0);

        run_os(1, 1, 1'b0, 1'b0);
        run_os(3, 2, 1'b0, 1'b0);
        run_ws(5, 1'b0);
        run_os(2, 3, 1'b0, 1'b1);
        run_ws(7, 1'b1);
        run_os(1, 2, 1'b1, 1'b0);
        run_ws(1, 1'b0);
        run_os(4, 1, 1'b0, 1'b0);

        @(negedge clk); #1;
        chk(pre_ready == 1'b0 && bc_ready == 1'b0 && res_valid == 1'b0, "R9",
            "idle after final tile", {pre_ready, bc_ready, res_valid}, 0);

        $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog: actual hung expected finish");
        $display("  [TB] %0d tests run, %0d failed", ntests + 1, nfail + 1);
        $finish;
    end

endmodule